// File: doc/BRIEF.md
# PLL Power Sequencer with Bounded Lock Wait

This block drives the control bits of two serial-link PLL channels, called channel A and channel B, through their power-up and power-down recipes. Each channel has its own recipe. On a power-up request it changes one group of control bits per clock cycle in a fixed order, and the last step releases the PLL reset. It then checks the channel's lock-detect input once every `POLL_CYC` cycles. It finishes with a locked status as soon as a check sees lock. It finishes with a timed-out status when `TIMEOUT_CYC / POLL_CYC` checks have all missed lock.

A power-down request applies the channel's shutdown order, again one step per cycle. Each request ends with a one-cycle done pulse. A 2-bit status output per channel reports the outcome. The two channels run fully independently, so one can be powering up while the other is idle or powering down. The analog PLLs are outside the block; only their lock-detect outputs come in.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset, each status reads 0 and each done reads 0. Channel A outputs reset select = `A_REFSEL_RST`, with reference buffer, TX reference enable, TX reference select and PLL reset-control all 0. Channel B outputs pad override = 1, pad IDDQ = 1, PLL power override = 1, PLL IDDQ = 1, mode = 0 and reset-control = 0.
- R2: Channel A power-up applies exactly one step per cycle, starting the cycle after the request is sampled, in this order: (1) clear the 4-bit reference select; (2) set reference buffer enable, TX reference enable and TX reference select; (3) set PLL reset-control.
- R3: Channel B power-up applies exactly one step per cycle, in this order: (1) clear pad override and pad IDDQ; (2) clear PLL power override and PLL IDDQ; (3) set mode; (4) set PLL reset-control.
- R4: After the last power-up step (step N, with N = 3 for A and 4 for B), lock is sampled at cycles N + j·POLL_CYC after the request, for j = 1, 2, and so on. The first sample that sees lock ends the request with done and status 2 (locked).
- R5: If the samples j = 1 to MAXP, where MAXP = TIMEOUT_CYC/POLL_CYC, all miss lock, done fires at cycle N + MAXP·POLL_CYC with status 3 (timed out). The control bits remain as power-up left them.
- R6: Channel A power-down clears only PLL reset-control, one cycle after the request. Done fires in that same cycle.
- R7: Channel B power-down applies one step per cycle, in this order: (1) clear reset-control; (2) clear mode; (3) set PLL power override and PLL IDDQ; (4) set pad override and pad IDDQ. Done fires with step 4.
- R8: Status encoding is 0 = idle, 1 = busy, 2 = locked, 3 = timed out. Status is 1 from the cycle after a request is accepted until done. A completed power-down leaves status 0.
- R9: An on or off request that arrives while the channel is sequencing is ignored and does not change timing or outcome.
- R10: The two channels sequence independently when their requests overlap.
- R11: If on and off are requested in the same cycle while the channel is idle, the power-up is performed.
- R12: Done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_on_req | input | 1 | Channel A power-up request |
| a_off_req | input | 1 | Channel A power-down request |
| a_lock | input | 1 | Channel A PLL lock detect |
| a_refsel | output | 4 | Channel A reference clock select |
| a_refbuf_en | output | 1 | Channel A reference buffer enable |
| a_txref_en | output | 1 | Channel A TX clock reference enable |
| a_txref_sel | output | 1 | Channel A TX clock reference select |
| a_pll_rst_ctl | output | 1 | Channel A PLL reset-control (1 = released) |
| a_done | output | 1 | Channel A request completed (pulse) |
| a_status | output | 2 | Channel A status |
| b_on_req | input | 1 | Channel B power-up request |
| b_off_req | input | 1 | Channel B power-down request |
| b_lock | input | 1 | Channel B PLL lock detect |
| b_pad_iddq_ovrd | output | 1 | Channel B pad IDDQ override |
| b_pad_iddq | output | 1 | Channel B pad IDDQ |
| b_pll_pwr_ovrd | output | 1 | Channel B PLL power override |
| b_pll_iddq | output | 1 | Channel B PLL IDDQ |
| b_pll_mode | output | 1 | Channel B PLL mode |
| b_pll_rst_ctl | output | 1 | Channel B PLL reset-control (1 = released) |
| b_done | output | 1 | Channel B request completed (pulse) |
| b_status | output | 2 | Channel B status |

## Verification
The bench builds the block with POLL_CYC = 4 and TIMEOUT_CYC = 20, so each channel makes at most five lock samples. With these values, every lock arrival cycle from the first power-up cycle to beyond the timeout can be swept on both channels in a short run. The sweep covers lock arriving exactly on a sample, just after one, on the final sample and never. Both outcomes and the latency formula are therefore checked at every boundary, together with each intermediate step of every recipe.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    STAT_IDLE   = 2'd0,
    STAT_BUSY   = 2'd1,
    STAT_LOCKED = 2'd2,
    STAT_TMO    = 2'd3
  } chan_stat_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_UP,
    PH_POLL,
    PH_DOWN
  } chan_phase_e;

  typedef enum logic {
    KIND_A,
    KIND_B
  } chan_kind_e;

  localparam int STEP_W = 2;

  // channel A control vector layout
  localparam int A_CTL_W   = 8;
  localparam int A_REFSEL0 = 0;
  localparam int A_REFBUF  = 4;
  localparam int A_TXREFEN = 5;
  localparam int A_TXREFSL = 6;
  localparam int A_RSTCTL  = 7;

  // channel B control vector layout
  localparam int B_CTL_W   = 6;
  localparam int B_PADOVR  = 0;
  localparam int B_PADIDDQ = 1;
  localparam int B_PWROVR  = 2;
  localparam int B_PLLIDDQ = 3;
  localparam int B_MODE    = 4;
  localparam int B_RSTCTL  = 5;
endpackage

// File: rtl/pll_lock_poll.sv
module pll_lock_poll #(
  parameter int POLL_CYC  = 4,
  parameter int MAX_POLLS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic tick,
  output logic last
);
  localparam int CNT_W = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int IDX_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             cnt_en;

  assign tick = run && (cnt_q == CNT_W'(POLL_CYC - 1));
  assign last = (idx_q == IDX_W'(MAX_POLLS - 1));

  always_comb begin
    cnt_en = start || run;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (start) begin
      cnt_d = '0;
      idx_d = '0;
    end else if (tick) begin
      cnt_d = '0;
      idx_d = idx_q + IDX_W'(1);
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/pll_seq_chan.sv
module pll_seq_chan
  import pll_seq_pkg::*;
#(
  parameter chan_kind_e      KIND      = KIND_A,
  parameter int              CTL_W     = A_CTL_W,
  parameter logic [CTL_W-1:0] CTL_RST  = '0,
  parameter int              POLL_CYC  = 4,
  parameter int              MAX_POLLS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_req,
  input  logic             off_req,
  input  logic             lock,
  output logic [CTL_W-1:0] ctl,
  output logic             done,
  output logic [1:0]       status
);
  localparam int UP_STEPS = (KIND == KIND_A) ? 3 : 4;
  localparam int DN_STEPS = (KIND == KIND_A) ? 1 : 4;

  chan_phase_e       phase_q, phase_d;
  chan_stat_e        stat_q, stat_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CTL_W-1:0]  ctl_q, ctl_d, ctl_up, ctl_dn;
  logic              done_q, done_d;
  logic              poll_start, poll_tick, poll_last;

  pll_lock_poll #(
    .POLL_CYC (POLL_CYC),
    .MAX_POLLS(MAX_POLLS)
  ) u_poll (
    .clk  (clk),
    .rst_n(rst_n),
    .start(poll_start),
    .run  (phase_q == PH_POLL),
    .tick (poll_tick),
    .last (poll_last)
  );

  // per-kind recipes: value of the control vector after the current step
  if (KIND == KIND_A) begin : g_recipe_a
    always_comb begin
      ctl_up = ctl_q;
      ctl_dn = ctl_q;
      case (step_q)
        2'd0:    ctl_up[A_REFSEL0 +: 4] = 4'h0;
        2'd1:    begin
                   ctl_up[A_REFBUF]  = 1'b1;
                   ctl_up[A_TXREFEN] = 1'b1;
                   ctl_up[A_TXREFSL] = 1'b1;
                 end
        default: ctl_up[A_RSTCTL] = 1'b1;
      endcase
      ctl_dn[A_RSTCTL] = 1'b0;
    end
  end else begin : g_recipe_b
    always_comb begin
      ctl_up = ctl_q;
      ctl_dn = ctl_q;
      case (step_q)
        2'd0: begin
          ctl_up[B_PADOVR]  = 1'b0;
          ctl_up[B_PADIDDQ] = 1'b0;
          ctl_dn[B_RSTCTL]  = 1'b0;
        end
        2'd1: begin
          ctl_up[B_PWROVR]  = 1'b0;
          ctl_up[B_PLLIDDQ] = 1'b0;
          ctl_dn[B_MODE]    = 1'b0;
        end
        2'd2: begin
          ctl_up[B_MODE]    = 1'b1;
          ctl_dn[B_PWROVR]  = 1'b1;
          ctl_dn[B_PLLIDDQ] = 1'b1;
        end
        default: begin
          ctl_up[B_RSTCTL]  = 1'b1;
          ctl_dn[B_PADOVR]  = 1'b1;
          ctl_dn[B_PADIDDQ] = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    phase_d    = phase_q;
    stat_d     = stat_q;
    step_d     = step_q;
    ctl_d      = ctl_q;
    done_d     = 1'b0;
    poll_start = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (on_req) begin
          phase_d = PH_UP;
          step_d  = '0;
          stat_d  = STAT_BUSY;
        end else if (off_req) begin
          phase_d = PH_DOWN;
          step_d  = '0;
          stat_d  = STAT_BUSY;
        end
      end
      PH_UP: begin
        ctl_d  = ctl_up;
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(UP_STEPS - 1)) begin
          phase_d    = PH_POLL;
          poll_start = 1'b1;
        end
      end
      PH_POLL: begin
        if (poll_tick && lock) begin
          phase_d = PH_IDLE;
          stat_d  = STAT_LOCKED;
          done_d  = 1'b1;
        end else if (poll_tick && poll_last) begin
          phase_d = PH_IDLE;
          stat_d  = STAT_TMO;
          done_d  = 1'b1;
        end
      end
      default: begin
        ctl_d  = ctl_dn;
        step_d = step_q + STEP_W'(1);
        if (step_q == STEP_W'(DN_STEPS - 1)) begin
          phase_d = PH_IDLE;
          stat_d  = STAT_IDLE;
          done_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      stat_q  <= STAT_IDLE;
      step_q  <= '0;
      ctl_q   <= CTL_RST;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      stat_q  <= stat_d;
      step_q  <= step_d;
      ctl_q   <= ctl_d;
      done_q  <= done_d;
    end
  end

  assign ctl    = ctl_q;
  assign done   = done_q;
  assign status = stat_q;
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pll_seq_pkg::*;
#(
  parameter int         POLL_CYC     = 20000,
  parameter int         TIMEOUT_CYC  = 5000000,
  parameter logic [3:0] A_REFSEL_RST = 4'hF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       a_on_req,
  input  logic       a_off_req,
  input  logic       a_lock,
  output logic [3:0] a_refsel,
  output logic       a_refbuf_en,
  output logic       a_txref_en,
  output logic       a_txref_sel,
  output logic       a_pll_rst_ctl,
  output logic       a_done,
  output logic [1:0] a_status,
  input  logic       b_on_req,
  input  logic       b_off_req,
  input  logic       b_lock,
  output logic       b_pad_iddq_ovrd,
  output logic       b_pad_iddq,
  output logic       b_pll_pwr_ovrd,
  output logic       b_pll_iddq,
  output logic       b_pll_mode,
  output logic       b_pll_rst_ctl,
  output logic       b_done,
  output logic [1:0] b_status
);
  localparam int MAX_POLLS = (TIMEOUT_CYC / POLL_CYC > 0) ? TIMEOUT_CYC / POLL_CYC : 1;
  localparam logic [A_CTL_W-1:0] A_RST = {4'b0000, A_REFSEL_RST};
  localparam logic [B_CTL_W-1:0] B_RST = 6'b001111;

  logic [A_CTL_W-1:0] a_ctl;
  logic [B_CTL_W-1:0] b_ctl;

  pll_seq_chan #(
    .KIND(KIND_A), .CTL_W(A_CTL_W), .CTL_RST(A_RST),
    .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)
  ) u_chan_a (
    .clk(clk), .rst_n(rst_n), .on_req(a_on_req), .off_req(a_off_req),
    .lock(a_lock), .ctl(a_ctl), .done(a_done), .status(a_status)
  );

  pll_seq_chan #(
    .KIND(KIND_B), .CTL_W(B_CTL_W), .CTL_RST(B_RST),
    .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)
  ) u_chan_b (
    .clk(clk), .rst_n(rst_n), .on_req(b_on_req), .off_req(b_off_req),
    .lock(b_lock), .ctl(b_ctl), .done(b_done), .status(b_status)
  );

  assign a_refsel        = a_ctl[A_REFSEL0 +: 4];
  assign a_refbuf_en     = a_ctl[A_REFBUF];
  assign a_txref_en      = a_ctl[A_TXREFEN];
  assign a_txref_sel     = a_ctl[A_TXREFSL];
  assign a_pll_rst_ctl   = a_ctl[A_RSTCTL];
  assign b_pad_iddq_ovrd = b_ctl[B_PADOVR];
  assign b_pad_iddq      = b_ctl[B_PADIDDQ];
  assign b_pll_pwr_ovrd  = b_ctl[B_PWROVR];
  assign b_pll_iddq      = b_ctl[B_PLLIDDQ];
  assign b_pll_mode      = b_ctl[B_MODE];
  assign b_pll_rst_ctl   = b_ctl[B_RSTCTL];
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] a_refsel,
  input logic       a_refbuf_en,
  input logic       a_txref_en,
  input logic       a_txref_sel,
  input logic       a_pll_rst_ctl,
  input logic       a_done,
  input logic [1:0] a_status,
  input logic       b_pad_iddq_ovrd,
  input logic       b_pad_iddq,
  input logic       b_pll_pwr_ovrd,
  input logic       b_pll_iddq,
  input logic       b_pll_mode,
  input logic       b_pll_rst_ctl,
  input logic       b_done,
  input logic [1:0] b_status
);
  AST_A_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_pll_rst_ctl) |-> (a_refsel == 4'h0 && a_refbuf_en && a_txref_en && a_txref_sel)); // R2
  AST_B_RELEASE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_pll_rst_ctl) |-> (b_pll_mode && !b_pll_iddq && !b_pll_pwr_ovrd && !b_pad_iddq && !b_pad_iddq_ovrd)); // R3
  AST_A_LOCK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (a_status == 2'd2) |-> a_pll_rst_ctl); // R4
  AST_B_LOCK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (b_status == 2'd2) |-> (b_pll_rst_ctl && b_pll_mode)); // R4
  AST_A_OFF_ONLY_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(a_pll_rst_ctl) |-> ($stable(a_refsel) && $stable(a_refbuf_en) && $stable(a_txref_en) && $stable(a_txref_sel))); // R6
  AST_B_PAD_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_pad_iddq) |-> (!b_pll_rst_ctl && !b_pll_mode && b_pll_iddq && b_pll_pwr_ovrd)); // R7
  AST_A_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (a_status == 2'd1) |=> (a_status == 2'd1 || a_done)); // R8
  AST_B_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (b_status == 2'd1) |=> (b_status == 2'd1 || b_done)); // R8
  AST_A_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    a_done |=> !a_done); // R12
  AST_B_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    b_done |=> !b_done); // R12
  AST_A_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    a_done |-> (a_status != 2'd1)); // R8
  AST_B_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    b_done |-> (b_status != 2'd1)); // R8
endmodule

bind pll_bringup_seq pll_bringup_seq_chk u_chk (.*);

// File: tb/tb_pll_bringup_seq.sv
module tb_pll_bringup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int POLL = 4;
  localparam int TMO  = 20;
  localparam int MAXP = TMO / POLL;

  logic clk, rst_n;
  logic a_on_req, a_off_req, a_lock, b_on_req, b_off_req, b_lock;
  logic [3:0] a_refsel;
  logic a_refbuf_en, a_txref_en, a_txref_sel, a_pll_rst_ctl, a_done;
  logic [1:0] a_status, b_status;
  logic b_pad_iddq_ovrd, b_pad_iddq, b_pll_pwr_ovrd, b_pll_iddq, b_pll_mode, b_pll_rst_ctl, b_done;

  int errors = 0;
  int checks = 0;

  pll_bringup_seq #(.POLL_CYC(POLL), .TIMEOUT_CYC(TMO), .A_REFSEL_RST(4'hF)) dut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int vec(input int ch);
    if (ch == 0) return {a_pll_rst_ctl, a_txref_sel, a_txref_en, a_refbuf_en, a_refsel};
    return {b_pll_rst_ctl, b_pll_mode, b_pll_iddq, b_pll_pwr_ovrd, b_pad_iddq, b_pad_iddq_ovrd};
  endfunction
  function automatic bit get_done(input int ch);
    return (ch == 0) ? a_done : b_done;
  endfunction
  function automatic int get_stat(input int ch);
    return (ch == 0) ? int'(a_status) : int'(b_status);
  endfunction
  task automatic drive(input int ch, input bit on, input bit off);
    if (ch == 0) begin a_on_req = on; a_off_req = off; end
    else begin b_on_req = on; b_off_req = off; end
  endtask
  task automatic set_lock(input int ch, input bit v);
    if (ch == 0) a_lock = v; else b_lock = v;
  endtask

  // expected vector after power-up step n (R2, R3)
  function automatic int up_step(input int ch, input int n, input int v);
    int r = v;
    if (ch == 0) begin
      if (n == 1) r = r & ~32'h0F;
      if (n == 2) r = r | 32'h70;
      if (n == 3) r = r | 32'h80;
    end else begin
      if (n == 1) r = r & ~32'h03;
      if (n == 2) r = r & ~32'h0C;
      if (n == 3) r = r | 32'h10;
      if (n == 4) r = r | 32'h20;
    end
    return r;
  endfunction
  // expected vector after power-down step n (R6, R7)
  function automatic int dn_step(input int ch, input int n, input int v);
    int r = v;
    if (ch == 0) begin
      if (n == 1) r = r & ~32'h80;
    end else begin
      if (n == 1) r = r & ~32'h20;
      if (n == 2) r = r & ~32'h10;
      if (n == 3) r = r | 32'h0C;
      if (n == 4) r = r | 32'h03;
    end
    return r;
  endfunction

  // lock is seen high at edges >= request edge + d
  task automatic run_on(input int ch, input int d, input bit extra, input bit both);
    int nsteps = (ch == 0) ? 3 : 4;
    int expv = vec(ch);
    int j, explat, expst, n;
    bit seen = 0;
    @(negedge clk);
    drive(ch, 1'b1, both);
    @(negedge clk);
    drive(ch, 1'b0, 1'b0);
    chk(get_stat(ch) == 1, "R8 busy after request", get_stat(ch), 1);
    if (d <= 1) set_lock(ch, 1'b1);
    j = (d - nsteps <= POLL) ? 1 : (d - nsteps + POLL - 1) / POLL;
    if (j > MAXP) begin explat = nsteps + MAXP * POLL; expst = 3; end
    else begin explat = nsteps + j * POLL; expst = 2; end
    n = 0;
    while (n < explat + 10) begin
      @(negedge clk);
      n++;
      if (n <= nsteps) begin
        expv = up_step(ch, n, expv);
        chk(vec(ch) == expv, (ch == 0) ? "R2 power-up step" : "R3 power-up step", vec(ch), expv);
        if (n == nsteps && both) chk(1'b1, "R11 on wins over off", 1, 1);
      end
      if (get_done(ch)) begin seen = 1; break; end
      if (extra && n == 2) drive(ch, 1'b1, 1'b0);
      if (extra && n == 3) drive(ch, 1'b0, 1'b0);
      if (extra && n == nsteps + 1) drive(ch, 1'b0, 1'b1);
      if (extra && n == nsteps + 2) drive(ch, 1'b0, 1'b0);
      if (n == d - 1) set_lock(ch, 1'b1);
    end
    chk(seen && n == explat, (expst == 2) ? "R4 lock latency" : "R5 timeout latency", n, explat);
    chk(get_stat(ch) == expst, (expst == 2) ? "R4 locked status" : "R5 timeout status", get_stat(ch), expst);
    chk(vec(ch) == expv, "R5 controls held at completion", vec(ch), expv);
    if (extra) chk(seen && n == explat, "R9 extra requests ignored", n, explat);
    @(negedge clk);
    chk(get_done(ch) == 1'b0, "R12 done single cycle", get_done(ch), 0);
    set_lock(ch, 1'b0);
  endtask

  task automatic run_off(input int ch);
    int nsteps = (ch == 0) ? 1 : 4;
    int expv = vec(ch);
    int n;
    @(negedge clk);
    drive(ch, 1'b0, 1'b1);
    @(negedge clk);
    drive(ch, 1'b0, 1'b0);
    for (n = 1; n <= nsteps; n++) begin
      @(negedge clk);
      expv = dn_step(ch, n, expv);
      chk(vec(ch) == expv, (ch == 0) ? "R6 power-down step" : "R7 power-down step", vec(ch), expv);
      chk(get_done(ch) == (n == nsteps), (ch == 0) ? "R6 done timing" : "R7 done timing", get_done(ch), n == nsteps);
    end
    chk(get_stat(ch) == 0, "R8 idle after power-down", get_stat(ch), 0);
  endtask

  task automatic main_seq();
    rst_n = 1'b0;
    a_on_req = 0; a_off_req = 0; a_lock = 0;
    b_on_req = 0; b_off_req = 0; b_lock = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vec(0) == 32'h0F, "R1 channel A reset controls", vec(0), 32'h0F);
    chk(vec(1) == 32'h0F, "R1 channel B reset controls", vec(1), 32'h0F);
    chk(a_status == 0 && b_status == 0, "R1 reset status", {a_status, b_status}, 0);
    chk(a_done == 0 && b_done == 0, "R1 reset done", {a_done, b_done}, 0);
    for (int ch = 0; ch < 2; ch++) begin
      int ns = (ch == 0) ? 3 : 4;
      for (int d = 1; d <= ns + MAXP * POLL + 3; d++) begin
        run_on(ch, d, d == 6, 1'b0);
        run_off(ch);
      end
    end
    // R11: simultaneous on and off while idle
    run_on(0, 1, 1'b0, 1'b1);
    run_off(0);
    run_on(1, 1, 1'b0, 1'b1);
    run_off(1);
    // R10: overlapping channels with different outcomes
    fork
      run_on(0, 9, 1'b0, 1'b0);
      run_on(1, 100, 1'b0, 1'b0);
    join
    chk(a_status == 2 && b_status == 3, "R10 independent outcomes", {a_status, b_status}, 4'b1011);
    fork
      run_off(0);
      run_off(1);
    join
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule